// File: doc/BRIEF.md
# Nonlinear Gain Error Estimator

This block runs beside one calibrated stage of a pipelined converter and measures, without pausing conversion, how the stage's residue gain deviates from its ideal value. Each accepted sample carries the residue code seen by the back end, the dither value injected into that stage and a flag saying whether the stage output sat in the central part of its swing. The block correlates residue with dither and averages the result over two windows at once. One window takes only centrally flagged samples. The other takes every sample.

The two averages are treated as the mean of an even quadratic gain curve over a narrow span (±5/8 of full scale) and over the whole span. From them the block solves for the constant term and the square-law coefficient of that curve. It then evaluates the curve at the centre of each residue level and writes one fixed-point gain per level into a table. The downstream corrector reads the table by level. The table is double-buffered, so a reader sees either the complete old set or the complete new set.

Top module: `nlge_estimator`

## Requirements
- R1: After reset, in_ready is 1, est_done and est_inverted are 0, and every table level reads 16384 (1.0 with 14 fractional bits).
- R2: A sample's contribution is residue times a dither weight: code 2'b01 is +1, 2'b11 is -1, and codes 2'b00 and 2'b10 are 0.
- R3: The central average Gc is the sum of contributions from the first 2^cfg_log2_central accepted samples with in_central=1 in the epoch, arithmetically shifted right by cfg_log2_central (floor), saturated to [-32768, 32767].
- R4: The full average Gf is formed the same way from the first 2^cfg_log2_full accepted samples of the epoch, whatever their in_central value.
- R5: Once both windows hold their full count, in_ready is 0 and stays 0 until the table swap; on the est_done cycle in_ready is 1 again and a new epoch starts from empty windows.
- R6: The coefficients are h1 = floor((Gf - Gc) * 20165 / 4096) and g0 = Gc - floor(h1 * 533 / 4096).
- R7: With N = 2^LVL_BITS levels, level i holds g0 + floor(h1 * m * m / N^2) with m = 2i + 1 - N, saturated to [-32768, 32767].
- R8: est_done is a one-cycle pulse; all new table values become readable in the est_done cycle and before it every level still reads the previous table.
- R9: est_inverted is 1 when Gc < Gf for the finished epoch; it changes only in an est_done cycle.
- R10: A window exponent above MAX_LOG2 (12 by default) is treated as MAX_LOG2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample is taken when in_valid and in_ready are both 1 |
| in_residue | input | RES_W | Signed back-end residue code |
| in_dither | input | 2 | Dither code, see R2 |
| in_central | input | 1 | Stage output lay in the central region |
| cfg_log2_central | input | CFG_W | log2 of the central window count |
| cfg_log2_full | input | CFG_W | log2 of the full window count |
| rd_level | input | LVL_BITS | Level index to read |
| rd_gain | output | 16 | Gain of that level, signed, 14 fractional bits |
| est_done | output | 1 | Pulse: new table in place |
| est_inverted | output | 1 | Central average fell below the full average |

## Verification
The estimator is tried with pseudo-random residues and dithers under every pairing of window exponents from 0 to 3, which separates the two window counts and the central-flag filtering from each other. A run that walks through all four dither codes in turn tells a correct weighting from one that counts the unused code, and a run of extreme residues drives both averages to opposite rails so that coefficient overflow and table saturation at both ends show up. A single long run with an over-range exponent shows whether the clamp holds, and each epoch reads the old table while the new one is being built to catch a non-atomic swap.

// File: rtl/nlge_pkg.sv
package nlge_pkg;
    localparam int GAIN_W      = 16;
    localparam int COEF_W      = 24;
    localparam int H1_RECIP    = 20165;
    localparam int GEO_RECIP   = 533;
    localparam int RECIP_SHIFT = 12;

    typedef logic signed [39:0]       wide_t;
    typedef logic signed [GAIN_W-1:0] gain_t;
    typedef logic signed [COEF_W-1:0] coef_t;

    localparam gain_t GAIN_ONE = 16'sd16384;
    localparam wide_t WIDE_MAX = 40'sd32767;
    localparam wide_t WIDE_MIN = -40'sd32768;

    typedef enum logic [1:0] {ST_ACC, ST_SOLVE, ST_FILL} est_state_e;

    function automatic gain_t sat_gain(input wide_t v);
        if (v > WIDE_MAX)      return 16'sh7fff;
        else if (v < WIDE_MIN) return -16'sh8000;
        else                   return gain_t'(v);
    endfunction
endpackage

// File: rtl/nlge_accum.sv
module nlge_accum
    import nlge_pkg::*;
#(
    parameter int RES_W    = 16,
    parameter int MAX_LOG2 = 12,
    parameter int CFG_W    = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    take,
    input  logic signed [RES_W-1:0] residue,
    input  logic [1:0]              dither,
    input  logic [CFG_W-1:0]        log2_n,
    output logic                    full,
    output gain_t                   avg
);
    localparam int CNT_W = MAX_LOG2 + 1;
    localparam int ACC_W = RES_W + 2 + MAX_LOG2;

    typedef struct packed {
        logic [CNT_W-1:0]        cnt;
        logic signed [ACC_W-1:0] acc;
    } acc_state_t;

    acc_state_t s_d, s_q;
    logic [CFG_W-1:0]        n_eff;
    logic [CNT_W-1:0]        limit;
    logic signed [ACC_W-1:0] res_ext;
    logic signed [ACC_W-1:0] term;
    wide_t                   shifted;

    always_comb begin
        n_eff   = (int'(log2_n) > MAX_LOG2) ? CFG_W'(MAX_LOG2) : log2_n;
        limit   = CNT_W'(1) << n_eff;
        full    = (s_q.cnt == limit);
        res_ext = {{(ACC_W-RES_W){residue[RES_W-1]}}, residue};
        case (dither)
            2'b01:   term = res_ext;
            2'b11:   term = -res_ext;
            default: term = '0;
        endcase
        shifted = wide_t'(s_q.acc) >>> n_eff;
        avg     = sat_gain(shifted);

        s_d = s_q;
        if (clear) begin
            s_d = '0;
        end else if (take && !full) begin
            s_d.cnt = s_q.cnt + CNT_W'(1);
            s_d.acc = s_q.acc + term;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/nlge_solver.sv
module nlge_solver
    import nlge_pkg::*;
(
    input  gain_t ge_central,
    input  gain_t ge_full,
    output coef_t h1,
    output coef_t geo,
    output logic  inverted
);
    wide_t diff_w, h1_w, corr_w, geo_w;

    always_comb begin
        diff_w   = wide_t'(ge_full) - wide_t'(ge_central);
        h1_w     = (diff_w * wide_t'(H1_RECIP)) >>> RECIP_SHIFT;
        corr_w   = (h1_w * wide_t'(GEO_RECIP)) >>> RECIP_SHIFT;
        geo_w    = wide_t'(ge_central) - corr_w;
        h1       = coef_t'(h1_w);
        geo      = coef_t'(geo_w);
        inverted = (ge_central < ge_full);
    end
endmodule

// File: rtl/nlge_level_gain.sv
module nlge_level_gain
    import nlge_pkg::*;
#(
    parameter int LVL_BITS = 3
) (
    input  coef_t               h1,
    input  coef_t               geo,
    input  logic [LVL_BITS-1:0] level,
    output gain_t               gain
);
    localparam int N_LVL = 1 << LVL_BITS;
    localparam int SQ_SH = 2 * LVL_BITS;

    wide_t mid, sq, bend;

    always_comb begin
        mid  = wide_t'(2 * int'(level) + 1 - N_LVL);
        sq   = mid * mid;
        bend = (wide_t'(h1) * sq) >>> SQ_SH;
        gain = sat_gain(wide_t'(geo) + bend);
    end
endmodule

// File: rtl/nlge_table.sv
module nlge_table
    import nlge_pkg::*;
#(
    parameter int LVL_BITS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [LVL_BITS-1:0] wr_idx,
    input  gain_t               wr_data,
    input  logic                swap,
    input  logic [LVL_BITS-1:0] rd_idx,
    output gain_t               rd_data
);
    localparam int N_LVL = 1 << LVL_BITS;

    typedef struct packed {
        logic                                act;
        logic [1:0][N_LVL-1:0][GAIN_W-1:0]   bank;
    } tbl_t;

    tbl_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (wr_en) t_d.bank[~t_q.act][wr_idx] = wr_data;
        if (swap)  t_d.act = ~t_q.act;
        rd_data = gain_t'(t_q.bank[t_q.act][rd_idx]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.act <= 1'b0;
            for (int b = 0; b < 2; b++) begin
                for (int i = 0; i < N_LVL; i++) begin
                    t_q.bank[b][i] <= GAIN_ONE;
                end
            end
        end else begin
            t_q <= t_d;
        end
    end
endmodule

// File: rtl/nlge_estimator.sv
module nlge_estimator
    import nlge_pkg::*;
#(
    parameter int RES_W    = 16,
    parameter int LVL_BITS = 3,
    parameter int MAX_LOG2 = 12,
    parameter int CFG_W    = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic signed [RES_W-1:0] in_residue,
    input  logic [1:0]              in_dither,
    input  logic                    in_central,
    input  logic [CFG_W-1:0]        cfg_log2_central,
    input  logic [CFG_W-1:0]        cfg_log2_full,
    input  logic [LVL_BITS-1:0]     rd_level,
    output logic signed [15:0]      rd_gain,
    output logic                    est_done,
    output logic                    est_inverted
);
    localparam int N_LVL = 1 << LVL_BITS;
    localparam int N_WIN = 2;
    localparam logic [LVL_BITS-1:0] LAST_IDX = LVL_BITS'(N_LVL - 1);

    typedef struct packed {
        est_state_e          state;
        logic [LVL_BITS-1:0] idx;
        coef_t               h1;
        coef_t               geo;
        logic                inv_pend;
        logic                inv;
        logic                done;
    } ctl_t;

    ctl_t  c_d, c_q;
    logic  accept;
    logic  win_clear;
    logic  [N_WIN-1:0] win_full;
    gain_t win_avg [N_WIN];
    logic  [N_WIN-1:0][CFG_W-1:0] win_cfg;
    coef_t sol_h1, sol_geo;
    logic  sol_inv;
    gain_t lvl_gain;
    logic  tbl_wr, tbl_swap;
    gain_t tbl_rd;

    assign win_cfg[0] = cfg_log2_central;
    assign win_cfg[1] = cfg_log2_full;

    // window 0 keeps only centrally flagged samples, window 1 keeps all
    for (genvar w = 0; w < N_WIN; w++) begin : g_win
        logic take_w;
        assign take_w = accept && ((w == 0) ? in_central : 1'b1);
        nlge_accum #(
            .RES_W(RES_W), .MAX_LOG2(MAX_LOG2), .CFG_W(CFG_W)
        ) u_acc (
            .clk(clk), .rst_n(rst_n), .clear(win_clear), .take(take_w),
            .residue(in_residue), .dither(in_dither), .log2_n(win_cfg[w]),
            .full(win_full[w]), .avg(win_avg[w])
        );
    end

    nlge_solver u_solver (
        .ge_central(win_avg[0]), .ge_full(win_avg[1]),
        .h1(sol_h1), .geo(sol_geo), .inverted(sol_inv)
    );

    nlge_level_gain #(.LVL_BITS(LVL_BITS)) u_level (
        .h1(c_q.h1), .geo(c_q.geo), .level(c_q.idx), .gain(lvl_gain)
    );

    nlge_table #(.LVL_BITS(LVL_BITS)) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr), .wr_idx(c_q.idx),
        .wr_data(lvl_gain), .swap(tbl_swap), .rd_idx(rd_level), .rd_data(tbl_rd)
    );

    always_comb begin
        c_d       = c_q;
        c_d.done  = 1'b0;
        tbl_wr    = 1'b0;
        tbl_swap  = 1'b0;
        win_clear = 1'b0;
        in_ready  = (c_q.state == ST_ACC) && !(&win_full);
        accept    = in_valid && in_ready;

        case (c_q.state)
            ST_ACC: begin
                if (&win_full) c_d.state = ST_SOLVE;
            end
            ST_SOLVE: begin
                c_d.h1       = sol_h1;
                c_d.geo      = sol_geo;
                c_d.inv_pend = sol_inv;
                c_d.idx      = '0;
                c_d.state    = ST_FILL;
            end
            ST_FILL: begin
                tbl_wr = 1'b1;
                if (c_q.idx == LAST_IDX) begin
                    tbl_swap  = 1'b1;
                    win_clear = 1'b1;
                    c_d.done  = 1'b1;
                    c_d.inv   = c_q.inv_pend;
                    c_d.state = ST_ACC;
                end else begin
                    c_d.idx = c_q.idx + LVL_BITS'(1);
                end
            end
            default: c_d.state = ST_ACC;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.state <= ST_ACC;
        end else begin
            c_q <= c_d;
        end
    end

    assign rd_gain      = tbl_rd;
    assign est_done     = c_q.done;
    assign est_inverted = c_q.inv;
endmodule

// File: rtl/nlge_estimator_chk.sv
module nlge_estimator_chk #(
    parameter int LVL_BITS = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_ready,
    input logic                est_done,
    input logic                est_inverted,
    input logic [LVL_BITS-1:0] rd_level,
    input logic signed [15:0]  rd_gain
);
    // R8: the completion strobe lasts exactly one cycle
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        est_done |=> !est_done);

    // R8: outside a swap the table cannot change under a steady read index
    p_table_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!est_done && $stable(rd_level)) |-> $stable(rd_gain));

    // R9: the ordering flag moves only with the completion strobe
    p_inv_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !est_done |-> $stable(est_inverted));

    // R5: the block was busy in the cycle before the swap
    p_busy_before_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        est_done |-> !$past(in_ready));

    // R5: intake reopens together with the swap
    p_ready_at_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        est_done |-> in_ready);

    // R5: once intake closes it stays closed for at least one more cycle
    p_ready_low_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ready) |=> !in_ready);
endmodule

bind nlge_estimator nlge_estimator_chk #(.LVL_BITS(LVL_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .est_done(est_done),
    .est_inverted(est_inverted), .rd_level(rd_level), .rd_gain(rd_gain)
);

// File: tb/nlge_estimator_test.sv
`timescale 1ns/1ps
module nlge_estimator_test;
    localparam int LVL = 3;
    localparam int NL  = 1 << LVL;
    localparam int MAXL = 12;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic               rst_n;
    logic               in_valid;
    logic               in_ready;
    logic signed [15:0] in_residue;
    logic [1:0]         in_dither;
    logic               in_central;
    logic [3:0]         cfg_c, cfg_f;
    logic [LVL-1:0]     rd_level;
    logic signed [15:0] rd_gain;
    logic               est_done;
    logic               est_inverted;

    nlge_estimator #(.RES_W(16), .LVL_BITS(LVL), .MAX_LOG2(MAXL), .CFG_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_residue(in_residue), .in_dither(in_dither), .in_central(in_central),
        .cfg_log2_central(cfg_c), .cfg_log2_full(cfg_f), .rd_level(rd_level),
        .rd_gain(rd_gain), .est_done(est_done), .est_inverted(est_inverted)
    );

    int          checks = 0;
    int          errors = 0;
    longint      m_sum [2];
    int          m_cnt [2];
    int          m_lim [2];
    int          m_sh  [2];
    longint      exp_tab [NL];
    bit          exp_inv;
    int unsigned lcg = 32'h1234_5678;

    task automatic check(input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic longint sat16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic send(input logic signed [15:0] r, input logic [1:0] d, input logic c);
        longint wgt;
        @(negedge clk);
        in_valid = 1'b1; in_residue = r; in_dither = d; in_central = c;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        wgt = (d == 2'b01) ? longint'(r) : (d == 2'b11) ? -longint'(r) : 0;
        if (m_cnt[1] < m_lim[1]) begin m_cnt[1]++; m_sum[1] += wgt; end
        if (c && m_cnt[0] < m_lim[0]) begin m_cnt[0]++; m_sum[0] += wgt; end
    endtask

    task automatic read_all(input string what);
        for (int i = 0; i < NL; i++) begin
            rd_level = LVL'(i);
            #0.1;
            check($sformatf("%s level %0d", what, i), rd_gain, exp_tab[i]);
        end
    endtask

    // mode 0: random, mode 1: opposite rails, mode 2: dither codes in turn
    task automatic run_epoch(input string tag, input int cc, input int cf, input int mode);
        longint gc, gf, h1, g0, mm;
        int k, w;
        logic signed [15:0] r;
        logic [1:0] d;
        logic c;
        @(negedge clk);
        cfg_c = 4'(cc); cfg_f = 4'(cf);
        for (int j = 0; j < 2; j++) begin
            m_sum[j] = 0; m_cnt[j] = 0;
            m_sh[j]  = ((j == 0 ? cc : cf) > MAXL) ? MAXL : (j == 0 ? cc : cf);
            m_lim[j] = 1 << m_sh[j];
        end
        k = 0;
        while (!(m_cnt[0] == m_lim[0] && m_cnt[1] == m_lim[1])) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            c = lcg[28] || (m_cnt[1] == m_lim[1]);
            r = lcg[23:8];
            d = lcg[26:25];
            if (mode == 1) begin
                c = (m_cnt[1] == m_lim[1]);
                r = c ? -16'sd32768 : 16'sd32767;
                d = 2'b01;
            end else if (mode == 2) begin
                d = 2'(k % 4);
            end
            send(r, d, c);
            k++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R5 intake closed after both windows fill"}, in_ready, 0);
        read_all({tag, " R8 previous table kept"});

        gc = sat16(m_sum[0] >>> m_sh[0]);
        gf = sat16(m_sum[1] >>> m_sh[1]);
        h1 = ((gf - gc) * 20165) >>> 12;
        g0 = gc - ((h1 * 533) >>> 12);
        for (int i = 0; i < NL; i++) begin
            mm = 2 * i + 1 - NL;
            exp_tab[i] = sat16(g0 + ((h1 * mm * mm) >>> (2 * LVL)));
        end
        exp_inv = (gc < gf);

        w = 0;
        while (!est_done && w < 100) begin @(negedge clk); w++; end
        check({tag, " R8 done pulse seen"}, est_done, 1);
        check({tag, " R5 intake reopened at swap"}, in_ready, 1);
        check({tag, " R9 inverted flag"}, est_inverted, exp_inv);
        read_all({tag, " R6 R7 new table"});
        @(negedge clk);
        check({tag, " R8 done lasts one cycle"}, est_done, 0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_residue = '0; in_dither = '0;
        in_central = 1'b0; cfg_c = '0; cfg_f = '0; rd_level = '0;
        for (int i = 0; i < NL; i++) exp_tab[i] = 16384;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 in_ready after reset", in_ready, 1);
        check("R1 est_done after reset", est_done, 0);
        check("R1 est_inverted after reset", est_inverted, 0);
        read_all("R1 reset table");

        run_epoch("R3", 2, 3, 0);
        run_epoch("R2", 1, 2, 2);
        run_epoch("R6", 1, 1, 1);
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                run_epoch($sformatf("R4 c%0d f%0d", a, b), a, b, 0);
            end
        end
        run_epoch("R10", 0, 15, 0);
        run_epoch("R10 central", 14, 1, 2);
        finish_run();
    end
endmodule